// File: doc/BRIEF.md
# I2C Register-File Target

This block is the target side of a two-wire I2C bus with sixteen bytes of storage behind it. It runs on a fast system clock and treats the bus lines as asynchronous inputs. A two-flop synchroniser feeds an edge detector, which finds SCL edges and finds start and stop conditions. The block drives the bus through a single open-drain enable, `sda_oe`. When `sda_oe` is 1 the pad pulls SDA low. When it is 0 the pad releases SDA.

The 7-bit bus address has two parts. The upper four bits are a parameter fixed at build time. The lower three bits come from strap pins, so up to eight copies can share one bus. A controller writes the register pointer as the first data byte of a write transfer. Further data bytes fill the registers from the pointer onward, and the pointer advances by one after each byte. To read, the controller writes the pointer with no data, then sends a repeated start and the address with the read bit set. Bytes are then returned from the stored pointer onward.

Local host logic has its own port. It reads any register combinationally and writes registers synchronously.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and every register reads 0x00 on `host_rdata`.
- R2: The controller sends an address byte MSB first: the 7-bit address, then the R/W bit (1 = read). If the 7 bits equal {ADDR_HI, addr_strap}, the target holds `sda_oe`=1 during the ninth SCL pulse (ACK).
- R3: For any other address, `sda_oe` stays 0 through the ninth pulse (NACK). Data bytes that follow in the same transfer leave every register unchanged and never cause the target to drive SDA.
- R4: If ADDR_HI is 4'b0000 or 4'b1111, the target never acknowledges any address.
- R5: In a write transfer, every data byte is acknowledged. The low four bits of the first data byte load the pointer. Each later byte is stored at the pointer, and the pointer then increments modulo 16 (register 15 is followed by register 0).
- R6: The pointer survives a repeated start. A read that follows returns, MSB first, the register at the stored pointer and then the registers after it.
- R7: While sending read data, the target sends the next byte after a controller ACK (SDA low on the ninth pulse). After a controller NACK it keeps SDA released until the next start.
- R8: A stop condition clears the pointer to 0. A read that begins right after a stop returns register 0 first.
- R9: A start or stop seen in the middle of a byte abandons that byte without storing it, and the transfer begins again with an address byte.
- R10: `sda_oe` only rises while synchronised SCL is low. The target samples SDA on SCL rising edges.
- R11: `host_rdata` shows the register selected by `host_addr`. A cycle with `host_we`=1 writes `host_wdata` into that register. If a bus write lands on the same cycle, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL as seen at the pad |
| sda_i | input | 1 | SDA as seen at the pad |
| addr_strap | input | 3 | Low three bits of the bus address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The address phase is exercised three ways:
- a matching address;
- an address that differs only in the strap bits;
- a reserved-prefix address sent to a second instance built with prefix 1111.

Together these separate correct address decoding from "always ACK" and from "compare prefix only". The write test starts the pointer near 15, so the wrap from 15 to 0 has to come out right. A combined read then shows whether the pointer survives a repeated start. A read issued right after a stop shows whether the stop clears the pointer. A byte cut off by a repeated start after four bits shows whether partial data is kept by mistake.

On every clock where the controller owns SDA, a behavioural model checks that the target has released the line.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [3:0] ADDR_HI = 4'b1010,
  parameter int         NREG    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [2:0]              addr_strap,
  output logic                    sda_oe,
  input  logic                    host_we,
  input  logic [$clog2(NREG)-1:0] host_addr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata
);
  localparam int   PW        = $clog2(NREG);
  localparam logic PREFIX_OK = (ADDR_HI != 4'h0) && (ADDR_HI != 4'hF);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;

  st_t           state;
  logic [3:0]    bitcnt;
  logic [6:0]    shreg;
  logic [7:0]    txb;
  logic [PW-1:0] ptr;
  logic          first, rw;
  logic [7:0]    regs [NREG];

  wire [7:0] rx_byte  = {shreg, sda_s};
  wire       addr_hit = PREFIX_OK && (rx_byte[7:1] == {ADDR_HI, addr_strap});
  wire       bus_wr   = scl_rise && (state == ST_WR) && (bitcnt == 4'd7) && !first
                        && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else if (bus_wr) regs[ptr] <= rx_byte;
    else if (host_we)    regs[host_addr] <= host_wdata;

  assign host_rdata = regs[host_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txb <= '0;
      ptr <= '0; first <= 1'b0; rw <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0; first <= 1'b1;
    end else if (stop_det) begin
      state <= ST_IDLE; bitcnt <= '0; sda_oe <= 1'b0; ptr <= '0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        bitcnt <= (bitcnt == 4'd8) ? 4'd0 : bitcnt + 4'd1;
        if (bitcnt < 4'd8) begin
          shreg <= rx_byte[6:0];
          if (bitcnt == 4'd7)
            case (state)
              ST_ADDR: if (addr_hit) rw <= rx_byte[0]; else state <= ST_IDLE;
              ST_WR: if (first) begin
                       ptr <= rx_byte[PW-1:0]; first <= 1'b0;
                     end else ptr <= ptr + 1'b1;
              default: ;
            endcase
        end else if (state == ST_ADDR) state <= rw ? ST_RD : ST_WR;
        else if (state == ST_RD && sda_s) state <= ST_IDLE;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) sda_oe <= (state != ST_RD);
        else if (state == ST_RD) begin
          if (bitcnt == 4'd0) begin
            txb <= regs[ptr]; ptr <= ptr + 1'b1; sda_oe <= ~regs[ptr][7];
          end else sda_oe <= ~txb[3'd7 - bitcnt[2:0]];
        end else sda_oe <= 1'b0;
      end
    end

  AST_OE_RISES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe); // R3
  AST_ACK_NINTH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && (state == ST_WR || state == ST_ADDR)) |-> (bitcnt == 4'd8 || bitcnt == 4'd0)); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) && !$past(start_det) |-> (ptr == '0 && state == ST_IDLE)); // R8
  AST_RESERVED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    !PREFIX_OK |-> (state != ST_WR && state != ST_RD)); // R4
endmodule

// File: tb/sim_i2c_regfile_target.sv
module sim_i2c_regfile_target;
  localparam int H = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_ctl = 1'b1;
  logic [2:0] strap = 3'b101;
  logic oe0, oe1;
  logic host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata, rdata1;
  wire sda_line = sda_ctl & ~oe0 & ~oe1;
  int compared = 0, mismatched = 0;
  logic exp_release = 1'b0;
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  i2c_regfile_target u0 (.clk, .rst_n, .scl_i(scl), .sda_i(sda_line), .addr_strap(strap),
    .sda_oe(oe0), .host_we, .host_addr, .host_wdata, .host_rdata);
  i2c_regfile_target #(.ADDR_HI(4'hF)) u1 (.clk, .rst_n, .scl_i(scl), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(oe1), .host_we(1'b0), .host_addr(4'd0),
    .host_wdata(8'd0), .host_rdata(rdata1));

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (exp_release) chk("R10 u0 releases SDA", oe0, 0);
    if (oe1) chk("R4 reserved-prefix instance drives SDA", oe1, 0);
  end

  task automatic w(input int n); repeat (n) @(posedge clk); endtask

  task automatic i2c_start;
    sda_ctl = 1; scl = 1; w(H); sda_ctl = 0; w(H); scl = 0;
  endtask
  task automatic i2c_rstart;
    w(2); sda_ctl = 1; w(H); scl = 1; w(H); sda_ctl = 0; w(H); scl = 0;
  endtask
  task automatic i2c_stop;
    w(2); sda_ctl = 0; w(H); scl = 1; w(H); sda_ctl = 1; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      w(2); sda_ctl = b[i]; w(H - 2); exp_release = 1; scl = 1; w(H); scl = 0;
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    exp_release = 0;
    w(2); sda_ctl = 1; w(H - 2); scl = 1; w(H / 2); #1 ack = ~sda_line; w(H / 2); scl = 0;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    exp_release = 0; sda_ctl = 1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl = 1; w(H / 2); #1 b[i] = sda_line; w(H / 2); scl = 0;
    end
    w(H / 2); sda_ctl = ~give_ack; w(H / 2); scl = 1; w(H); scl = 0;
    w(2); sda_ctl = 1;
    if (!give_ack) begin w(H); exp_release = 1; end
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    @(posedge clk); host_addr = a[3:0]; @(negedge clk); d = host_rdata;
  endtask

  task automatic host_write(input int a, input logic [7:0] d);
    @(posedge clk); host_addr = a[3:0]; host_wdata = d; host_we = 1;
    @(posedge clk); host_we = 0; model[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    w(4); rst_n = 1; w(4);

    @(negedge clk); chk("R1 sda_oe after reset", oe0, 0);
    for (int i = 0; i < 16; i++) begin host_read(i, d); chk("R1 register reset value", d, 0); end

    host_write(1, 8'h77);
    host_read(1, d); chk("R11 host write then read", d, 8'h77);

    // R2 R5: pointer 14, three bytes wrap to register 0
    i2c_start;
    write_byte(8'hAA, ack); chk("R2 matching address ACK", ack, 1);
    write_byte(8'h0E, ack); chk("R5 pointer byte ACK", ack, 1);
    write_byte(8'h11, ack); chk("R5 data ACK", ack, 1); model[14] = 8'h11;
    write_byte(8'h22, ack); chk("R5 data ACK", ack, 1); model[15] = 8'h22;
    write_byte(8'h33, ack); chk("R5 data ACK after wrap", ack, 1); model[0] = 8'h33;
    i2c_stop;
    for (int i = 0; i < 16; i++) begin host_read(i, d); chk("R5 register after write", d, model[i]); end

    // R3: strap mismatch
    i2c_start;
    write_byte(8'hA6, ack); chk("R3 wrong strap NACK", ack, 0);
    write_byte(8'h05, ack); chk("R3 ignored byte NACK", ack, 0);
    write_byte(8'hEE, ack); chk("R3 ignored byte NACK", ack, 0);
    i2c_stop;
    for (int i = 0; i < 16; i++) begin host_read(i, d); chk("R3 registers untouched", d, model[i]); end

    // R4: reserved prefix 1111 never acknowledged
    i2c_start;
    write_byte(8'hFA, ack); chk("R4 reserved prefix NACK", ack, 0);
    i2c_stop;

    // R6 R7: combined read from pointer 14
    i2c_start;
    write_byte(8'hAA, ack); chk("R6 address ACK", ack, 1);
    write_byte(8'h0E, ack); chk("R6 pointer ACK", ack, 1);
    i2c_rstart;
    write_byte(8'hAB, ack); chk("R6 read address ACK", ack, 1);
    read_byte(1, d); chk("R6 first read byte", d, model[14]);
    read_byte(1, d); chk("R7 continue after ACK", d, model[15]);
    read_byte(0, d); chk("R7 wrapped byte before NACK", d, model[0]);
    w(4 * H); chk("R7 released after NACK", oe0, 0);
    i2c_stop;

    // R8: read right after stop starts at register 0
    i2c_start;
    write_byte(8'hAB, ack); chk("R8 read address ACK", ack, 1);
    read_byte(1, d); chk("R8 register 0 after stop", d, model[0]);
    read_byte(0, d); chk("R8 register 1 next", d, model[1]);
    i2c_stop;

    // R9: byte cut by repeated start is dropped
    i2c_start;
    write_byte(8'hAA, ack); chk("R9 address ACK", ack, 1);
    write_byte(8'h02, ack); chk("R9 pointer ACK", ack, 1);
    send_bits(8'hF0, 4);
    i2c_rstart;
    write_byte(8'hAA, ack); chk("R9 address ACK after restart", ack, 1);
    write_byte(8'h08, ack); chk("R9 new pointer ACK", ack, 1);
    write_byte(8'h9C, ack); chk("R9 data ACK", ack, 1); model[8] = 8'h9C;
    i2c_stop;
    host_read(2, d); chk("R9 partial byte not stored", d, model[2]);
    host_read(8, d); chk("R9 new transfer stored", d, 8'h9C);

    // R11: host write visible over the bus
    host_write(6, 8'hC3);
    i2c_start;
    write_byte(8'hAA, ack); write_byte(8'h06, ack);
    i2c_rstart;
    write_byte(8'hAB, ack);
    read_byte(0, d); chk("R11 host-written byte over bus", d, 8'hC3);
    i2c_stop;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule